// File: doc/BRIEF.md
# Segmented Audio DAC Code Splitter

This block is the digital control half of a three-segment audio DAC. Each incoming signed 16-bit sample is turned into an unsigned offset code and cut into three fields. The upper byte picks one of 256 equal intervals on a resistor string, and with it a pair of neighbouring potentials. The middle nibble sets a pulse-width choice between the lower and the upper potential of that pair over a frame of 16 modulator clocks. The low nibble drives two complementary level-shift codes whose sum never changes.

Samples arrive with a one-cycle strobe at any point in a frame. A strobed sample waits in a pending register and is applied at the next frame boundary, so the tap, level-shift and pulse-width outputs of one frame always belong to one sample. With reset asserted the outputs rest at the analog mid-point.

Top module: `segdac_splitter`

## Requirements
- R1: The sample is two's complement; the offset code is the sample with bit 15 inverted, so input 0x0000 gives code 0x8000, 0x8000 gives 0x0000 and 0x7FFF gives 0xFFFF.
- R2: `tap_sel` equals bits 15 to 8 of the offset code of the sample in force.
- R3: Frame slots are numbered 0 to 15, slot 0 being the first clock period after reset is released and every 16th period after it; in slot s, `pick_upper` is 1 exactly when s is less than bits 7 to 4 of the offset code, so it is never 1 in slot 15 and only turns on at slot 0.
- R4: `lvl_hi` equals bits 3 to 0 of the offset code and `lvl_lo` equals 15 minus that value, so the two always add up to 15.
- R5: While reset is high and in the frame after it, the outputs show mid-scale (`tap_sel` 0x80, `lvl_hi` 0, `lvl_lo` 15, `pick_upper` 0), and any pending sample is discarded.
- R6: `tap_sel`, `lvl_hi` and `lvl_lo` change only at the start of slot 0; a sample strobed in any slot of a frame, the last slot included, is in force for the whole of the next frame.
- R7: When several samples are strobed in one frame the last one is used; when none is strobed, the sample in force is repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock, one frame slot per cycle |
| rst | input | 1 | Synchronous active-high reset and initialisation |
| smp_valid | input | 1 | One-cycle strobe marking a new sample |
| smp_data | input | 16 | Signed two's-complement sample |
| tap_sel | output | 8 | Resistor-string interval select |
| pick_upper | output | 1 | 1 selects the upper potential of the pair, 0 the lower |
| lvl_hi | output | 4 | High-side level-shift code |
| lvl_lo | output | 4 | Low-side level-shift code |

## Verification
The sample strobe and the frame boundary can land in the same cycle: a strobe in slot 15 is captured by the very edge that loads the active fields, so it must bypass the pending register and win over an older pending sample. The sweep places strobes in every slot position, including slot 15 alone and slot 15 following an earlier strobe in the same frame, and judges each case by comparing every slot of the following frame against the fields computed arithmetically from the last strobed sample. A reset issued mid-frame after a strobe shows whether the pending sample is dropped.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
  // Default field widths of the three-way code split
  localparam int DEF_TAP_W = 8;
  localparam int DEF_PWM_W = 4;
  localparam int DEF_LVL_W = 4;

  typedef enum logic {
    PICK_LOWER = 1'b0,
    PICK_UPPER = 1'b1
  } pick_t;
endpackage

// File: rtl/segdac_code_split.sv
// Turns a signed sample into offset binary and cuts it into the three fields.
module segdac_code_split #(
  parameter int TAP_W = 8,
  parameter int PWM_W = 4,
  parameter int LVL_W = 4,
  localparam int CODE_W = TAP_W + PWM_W + LVL_W
) (
  input  logic [CODE_W-1:0] sample,
  output logic [TAP_W-1:0]  tap_f,
  output logic [PWM_W-1:0]  pwm_f,
  output logic [LVL_W-1:0]  lvl_f
);
  logic [CODE_W-1:0] ofs;

  always_comb begin
    ofs   = {~sample[CODE_W-1], sample[CODE_W-2:0]};
    tap_f = ofs[CODE_W-1 -: TAP_W];
    pwm_f = ofs[LVL_W +: PWM_W];
    lvl_f = ofs[LVL_W-1:0];
  end
endmodule

// File: rtl/segdac_slot_timer.sv
// Free-running slot counter; a frame is 2**PWM_W slots.
module segdac_slot_timer #(
  parameter int PWM_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  output logic [PWM_W-1:0] slot_nx,
  output logic             frame_end
);
  logic [PWM_W-1:0] slot_q;

  always_comb begin
    slot_nx   = slot_q + 1'b1;
    frame_end = &slot_q;
  end

  always_ff @(posedge clk) begin
    if (rst) slot_q <= '0;
    else     slot_q <= slot_nx;
  end
endmodule

// File: rtl/segdac_pwm_cmp.sv
// Registered pulse-width select: upper potential while the slot is below the duty value.
module segdac_pwm_cmp #(
  parameter int PWM_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PWM_W-1:0] slot_nx,
  input  logic [PWM_W-1:0] duty_nx,
  output logic             pick
);
  import segdac_pkg::*;

  pick_t pick_q;

  always_ff @(posedge clk) begin
    if (rst)                    pick_q <= PICK_LOWER;
    else if (slot_nx < duty_nx) pick_q <= PICK_UPPER;
    else                        pick_q <= PICK_LOWER;
  end

  assign pick = pick_q;
endmodule

// File: rtl/segdac_splitter.sv
module segdac_splitter #(
  parameter int TAP_W = segdac_pkg::DEF_TAP_W,
  parameter int PWM_W = segdac_pkg::DEF_PWM_W,
  parameter int LVL_W = segdac_pkg::DEF_LVL_W,
  localparam int CODE_W = TAP_W + PWM_W + LVL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] smp_data,
  output logic [TAP_W-1:0]  tap_sel,
  output logic              pick_upper,
  output logic [LVL_W-1:0]  lvl_hi,
  output logic [LVL_W-1:0]  lvl_lo
);
  localparam logic [TAP_W-1:0] TAP_MID = {1'b1, {(TAP_W-1){1'b0}}};
  localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

  // Fields of the incoming sample
  logic [TAP_W-1:0] in_tap;
  logic [PWM_W-1:0] in_pwm;
  logic [LVL_W-1:0] in_lvl;

  // Pending sample, waiting for the next frame
  logic [TAP_W-1:0] pend_tap;
  logic [PWM_W-1:0] pend_pwm;
  logic [LVL_W-1:0] pend_lvl;

  // Sample that the next frame will use (strobe in the boundary cycle wins)
  logic [TAP_W-1:0] nx_tap;
  logic [PWM_W-1:0] nx_pwm;
  logic [LVL_W-1:0] nx_lvl;

  // Sample in force in the current frame
  logic [TAP_W-1:0] act_tap;
  logic [PWM_W-1:0] act_pwm;
  logic [LVL_W-1:0] act_hi;
  logic [LVL_W-1:0] act_lo;

  logic [PWM_W-1:0] slot_nx;
  logic [PWM_W-1:0] duty_nx;
  logic             frame_end;

  segdac_code_split #(
    .TAP_W(TAP_W), .PWM_W(PWM_W), .LVL_W(LVL_W)
  ) u_split (
    .sample(smp_data),
    .tap_f (in_tap),
    .pwm_f (in_pwm),
    .lvl_f (in_lvl)
  );

  segdac_slot_timer #(.PWM_W(PWM_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .slot_nx  (slot_nx),
    .frame_end(frame_end)
  );

  always_comb begin
    nx_tap  = smp_valid ? in_tap : pend_tap;
    nx_pwm  = smp_valid ? in_pwm : pend_pwm;
    nx_lvl  = smp_valid ? in_lvl : pend_lvl;
    duty_nx = frame_end ? nx_pwm : act_pwm;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_tap <= TAP_MID;
      pend_pwm <= '0;
      pend_lvl <= '0;
    end else if (smp_valid) begin
      pend_tap <= in_tap;
      pend_pwm <= in_pwm;
      pend_lvl <= in_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_tap <= TAP_MID;
      act_pwm <= '0;
      act_hi  <= '0;
      act_lo  <= LVL_MAX;
    end else if (frame_end) begin
      act_tap <= nx_tap;
      act_pwm <= nx_pwm;
      act_hi  <= nx_lvl;
      act_lo  <= LVL_MAX - nx_lvl;
    end
  end

  segdac_pwm_cmp #(.PWM_W(PWM_W)) u_pwm (
    .clk    (clk),
    .rst    (rst),
    .slot_nx(slot_nx),
    .duty_nx(duty_nx),
    .pick   (pick_upper)
  );

  assign tap_sel = act_tap;
  assign lvl_hi  = act_hi;
  assign lvl_lo  = act_lo;
endmodule

// File: rtl/segdac_splitter_chk.sv
module segdac_splitter_chk #(
  parameter int TAP_W = 8,
  parameter int PWM_W = 4,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [TAP_W-1:0] tap_sel,
  input logic             pick_upper,
  input logic [LVL_W-1:0] lvl_hi,
  input logic [LVL_W-1:0] lvl_lo
);
  localparam int LVL_MAX = (1 << LVL_W) - 1;
  localparam int TAP_MID = 1 << (TAP_W - 1);
  localparam logic [PWM_W-1:0] LAST = {PWM_W{1'b1}};

  // Independent slot count of the checker
  logic [PWM_W-1:0] ck_slot;
  always_ff @(posedge clk) begin
    if (rst) ck_slot <= '0;
    else     ck_slot <= ck_slot + 1'b1;
  end

  assert_lvl_sum_R4: assert property (@(posedge clk) disable iff (rst)
    (int'(lvl_hi) + int'(lvl_lo)) == LVL_MAX);

  assert_hold_in_frame_R6: assert property (@(posedge clk) disable iff (rst)
    (ck_slot != LAST) |=> ($stable(tap_sel) && $stable(lvl_hi) && $stable(lvl_lo)));

  assert_pick_rise_slot0_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(pick_upper) |-> (ck_slot == '0));

  assert_pick_low_last_R3: assert property (@(posedge clk) disable iff (rst)
    (ck_slot == LAST) |-> !pick_upper);

  assert_mid_after_reset_R5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (int'(tap_sel) == TAP_MID && lvl_hi == '0 &&
                    int'(lvl_lo) == LVL_MAX && !pick_upper));
endmodule

bind segdac_splitter segdac_splitter_chk #(
  .TAP_W(TAP_W), .PWM_W(PWM_W), .LVL_W(LVL_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tap_sel   (tap_sel),
  .pick_upper(pick_upper),
  .lvl_hi    (lvl_hi),
  .lvl_lo    (lvl_lo)
);

// File: tb/sim_segdac_splitter.sv
module sim_segdac_splitter;
  logic        clk = 1'b0;
  logic        rst;
  logic        smp_valid;
  logic [15:0] smp_data;
  logic [7:0]  tap_sel;
  logic        pick_upper;
  logic [3:0]  lvl_hi;
  logic [3:0]  lvl_lo;

  int checks = 0;
  int errors = 0;
  logic [15:0] cur;

  always #2 clk = ~clk;

  segdac_splitter u0 (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .tap_sel(tap_sel), .pick_upper(pick_upper), .lvl_hi(lvl_hi), .lvl_lo(lvl_lo)
  );

  task automatic expect_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // All outputs in slot s for raw sample smp (R2, R3, R4, R6)
  task automatic check_slot(input logic [15:0] smp, input int s);
    logic [15:0] ob;
    ob = smp ^ 16'h8000;
    expect_eq("R2/R6", "tap_sel", int'(tap_sel), int'(ob[15:8]));
    expect_eq("R4", "lvl_hi", int'(lvl_hi), int'(ob[3:0]));
    expect_eq("R4", "lvl_lo", int'(lvl_lo), 15 - int'(ob[3:0]));
    expect_eq("R3", "pick_upper", int'(pick_upper), (s < int'(ob[7:4])) ? 1 : 0);
  endtask

  // One frame from slot 0: check every slot, strobe va at slot sa and vb at slot sb
  task automatic play_frame(input logic [15:0] show, input int sa, input logic [15:0] va,
                            input int sb, input logic [15:0] vb);
    for (int s = 0; s < 16; s++) begin
      check_slot(show, s);
      smp_valid = (s == sa) || (s == sb);
      smp_data  = (s == sb) ? vb : ((s == sa) ? va : 16'h5AA5);
      @(negedge clk);
    end
    smp_valid = 1'b0;
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    smp_valid = 1'b0;
    smp_data = 16'h0;
    repeat (3) @(negedge clk);
    // R5: values during reset
    expect_eq("R5", "tap_sel in reset", int'(tap_sel), 8'h80);
    expect_eq("R5", "lvl_lo in reset", int'(lvl_lo), 15);
    rst = 1'b0;
    // now in slot 0 of the first frame; mid-scale equals raw input 0
    expect_eq("R5", "pick after reset", int'(pick_upper), 0);
    expect_eq("R5", "lvl_hi after reset", int'(lvl_hi), 0);
    play_frame(16'h0000, -1, 16'h0, -1, 16'h0);   // R7: nothing strobed, mid repeats

    // R1: extremes of the two's complement range
    play_frame(16'h0000, 4, 16'h8000, -1, 16'h0);
    expect_eq("R1", "tap for 0x8000", int'(tap_sel), 0);
    play_frame(16'h8000, 15, 16'h7FFF, -1, 16'h0);
    expect_eq("R1", "tap for 0x7FFF", int'(tap_sel), 255);
    expect_eq("R1", "lvl_hi for 0x7FFF", int'(lvl_hi), 15);
    play_frame(16'h7FFF, 9, 16'h0000, -1, 16'h0);
    expect_eq("R1", "tap for 0x0000", int'(tap_sel), 128);
    cur = 16'h0000;

    // Sweep every duty and level value, strobes in every slot
    for (int i = 0; i < 256; i++) begin
      logic [15:0] v;
      logic [15:0] w;
      logic [7:0]  hi;
      hi = 8'(i * 29 + 3);
      v  = {hi, 8'(i)};
      w  = {~hi, 8'(255 - i)};
      if (i % 5 == 0) begin
        // R7 and the boundary collision: earlier strobe overridden at slot 15
        play_frame(cur, i % 8, v, 15, w);
        cur = w;
      end else if (i % 7 == 0) begin
        // R7: two mid-frame strobes, the later one counts
        play_frame(cur, i % 6, w, 6 + (i % 9), v);
        cur = v;
      end else begin
        play_frame(cur, i % 16, v, -1, 16'h0);
        cur = v;
      end
    end
    // R7: repeat without a new strobe
    play_frame(cur, -1, 16'h0, -1, 16'h0);
    play_frame(cur, -1, 16'h0, -1, 16'h0);

    // R5: reset in mid-frame drops the pending sample
    for (int s = 0; s < 6; s++) begin
      check_slot(cur, s);
      smp_valid = (s == 2);
      smp_data  = 16'h1234;
      @(negedge clk);
    end
    smp_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    play_frame(16'h0000, -1, 16'h0, -1, 16'h0);
    play_frame(16'h0000, -1, 16'h0, -1, 16'h0);
    expect_eq("R5", "pending dropped tap", int'(tap_sel), 8'h80);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule